// File: doc/BRIEF.md
# MII Receive Frame Error Classifier

This block watches the four-bit receive side of a media-independent interface (data nibble, data-valid, receive-error and carrier-sense) and sorts every finished reception into error classes. It hunts for the start-of-frame delimiter and assembles nibbles into bytes, low nibble first. It then runs a CRC-32 over those bytes and counts them. When the reception closes, it emits single-cycle event pulses. A statistics counter bank downstream turns each pulse into one increment.

Five kinds of event are reported. They are a coding fault seen on the line, a bad checksum over whole bytes, a bad checksum with a leftover half byte, a frame beyond the maximum length, and a frame lost to a receive buffer overrun. A sixth "errored" pulse accompanies any of them, so a single counter can total all bad receptions.

Top module: `mii_rx_err_classifier`

## Requirements
- R1: If `rx_er` is high on any cycle in which `rx_dv` is high during a reception, `ev_symbol` pulses exactly once at the end of that reception, however many cycles `rx_er` was high.
- R2: Bytes are formed low nibble first from the data after the delimiter, and the CRC-32 runs over them including the four-byte FCS. The CRC is reflected, uses polynomial 0x04C11DB7 and starts at all ones, and the FCS is sent least significant byte first. The CRC is good when the bit-reversed register equals 0xC704DD7B. With an even data nibble count and a bad CRC, `ev_fcs` pulses.
- R3: With an odd data nibble count, the trailing nibble is ignored and the CRC is judged over the whole bytes only. If that CRC is bad, `ev_align` pulses and `ev_fcs` stays low. If it is good, no event pulses.
- R4: `ev_long` pulses when more than MAX_BYTES (default 1518) bytes, FCS included, follow the delimiter. Exactly MAX_BYTES bytes is not flagged.
- R5: If `fifo_ovr` is high on any cycle of an open reception, `ev_missed` pulses at its end. `fifo_ovr` while no reception is open has no effect.
- R6: `ev_errored` pulses in the same cycle as any other event, and never alone.
- R7: A reception closes on the first cycle in which both `rx_dv` and `crs` are low. All of its events appear together, for one cycle, right after the next clock edge. While `crs` stays high after `rx_dv` falls, no event appears.
- R8: Data counting starts only after a nibble 0x5 directly followed by nibble 0xD with `rx_dv` high. A reception without that pair reports only symbol and overrun events.
- R9: While `rst_n` is low, every event output is low from the next clock edge on.
- R10: A delimited frame of legal length with good CRC, no `rx_er` and no overrun produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 4 | Receive data nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive coding error |
| crs | input | 1 | Carrier sense |
| fifo_ovr | input | 1 | Receive data or status buffer overrun |
| ev_symbol | output | 1 | Symbol error event pulse |
| ev_fcs | output | 1 | Checksum error event pulse (whole bytes) |
| ev_align | output | 1 | Alignment error event pulse (dribble nibble) |
| ev_long | output | 1 | Oversize frame event pulse |
| ev_missed | output | 1 | Overrun-dropped frame event pulse |
| ev_errored | output | 1 | Any-error event pulse |

## Verification
Any wrong internal state stays hidden until the reception closes, and then shows as a wrong event vector one cycle after `rx_dv` and `crs` both drop. A broken CRC step or a wrong byte assembly turns every good frame into a checksum event. A wrong nibble phase swaps checksum and alignment events. A byte counter that is off by one shows only at the 1518 and 1519 byte boundary. A stuck flag shows as an event on the next, clean, frame.

// File: rtl/mii_rx_pkg.sv
// Shared constants, state type and CRC helpers for the MII receive
// error classifier. Assumes the reflected (LSB-first) CRC-32 form.
package mii_rx_pkg;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_GOOD_RES  = 32'hC704DD7B;
    localparam logic [3:0]  NIB_PREAMBLE  = 4'h5;
    localparam logic [3:0]  NIB_DELIM     = 4'hD;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_HUNT = 2'd1,
        RX_DATA = 2'd2
    } rx_state_e;

    // One byte step of the reflected CRC-32.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'h0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
        end
        return r;
    endfunction

    // Bit reversal of a 32-bit word.
    function automatic logic [31:0] rev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = v[31-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/mii_rx_framer.sv
// Reception tracker: opens on rx_dv, hunts for the 0x5,0xD delimiter,
// pairs data nibbles into bytes (low nibble first) and flags the close
// of a reception (rx_dv and crs both low). Assumes one nibble per clock.
module mii_rx_framer
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rxd,
    input  logic       rx_dv,
    input  logic       crs,
    output logic       rx_open,
    output logic       in_data,
    output logic       sfd_hit,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       nib_odd,
    output logic       frame_end
);

    rx_state_e  state_q;
    logic       prev_pre_q;
    logic       phase_q;
    logic [3:0] low_q;

    // Decode of the current reception state and incoming nibble.
    always_comb begin
        rx_open   = (state_q != RX_IDLE);
        in_data   = (state_q == RX_DATA);
        frame_end = rx_open && !rx_dv && !crs;
        sfd_hit   = (state_q == RX_HUNT) && rx_dv && (rxd == NIB_DELIM) && prev_pre_q;
        byte_vld  = in_data && rx_dv && phase_q;
        byte_data = {rxd, low_q};
        nib_odd   = phase_q;
    end

    // State, delimiter history and nibble pairing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RX_IDLE;
            prev_pre_q <= 1'b0;
            phase_q    <= 1'b0;
            low_q      <= 4'h0;
        end else begin
            case (state_q)
                RX_IDLE: begin
                    if (rx_dv) begin
                        state_q    <= RX_HUNT;
                        prev_pre_q <= (rxd == NIB_PREAMBLE);
                    end
                end
                RX_HUNT: begin
                    if (frame_end) begin
                        state_q <= RX_IDLE;
                    end else if (rx_dv) begin
                        if (sfd_hit) begin
                            state_q <= RX_DATA;
                            phase_q <= 1'b0;
                        end
                        prev_pre_q <= (rxd == NIB_PREAMBLE);
                    end
                end
                RX_DATA: begin
                    if (frame_end) begin
                        state_q <= RX_IDLE;
                        phase_q <= 1'b0;
                    end else if (rx_dv) begin
                        phase_q <= !phase_q;
                        if (!phase_q) low_q <= rxd;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mii_rx_crc32.sv
// Running CRC-32 over assembled receive bytes. Seeded at the delimiter;
// crc_ok reports the good-frame residue. Assumes the FCS is included.
module mii_rx_crc32
    import mii_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       byte_vld,
    input  logic [7:0] byte_data,
    output logic       crc_ok
);

    logic [31:0] crc_q;

    // Seed on delimiter, fold in each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        crc_q <= CRC_SEED;
        else if (clear)    crc_q <= CRC_SEED;
        else if (byte_vld) crc_q <= crc32_step(crc_q, byte_data);
    end

    // Residue compare in normal bit order.
    always_comb crc_ok = (rev32(crc_q) == CRC_GOOD_RES);

endmodule

// File: rtl/mii_rx_len_cnt.sv
// Saturating byte counter for oversize detection. Counts bytes after the
// delimiter including FCS; saturates one above MAX_BYTES.
module mii_rx_len_cnt #(
    parameter int MAX_BYTES = 1518
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic byte_vld,
    output logic too_long
);

    localparam int              CW    = $clog2(MAX_BYTES + 2);
    localparam logic [CW-1:0]   LIMIT = CW'(MAX_BYTES);
    localparam logic [CW-1:0]   SAT   = CW'(MAX_BYTES + 1);

    logic [CW-1:0] cnt_q;

    // Count bytes, holding at SAT.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clear)                      cnt_q <= '0;
        else if (byte_vld && cnt_q != SAT)   cnt_q <= cnt_q + 1'b1;
    end

    // Oversize once the count passes the limit.
    always_comb too_long = (cnt_q > LIMIT);

endmodule

// File: rtl/mii_rx_err_classifier.sv
// Top of the MII receive error classifier. Collects per-reception flags
// and issues all event pulses together one cycle after reception close.
// Assumes fifo_ovr is asserted by the buffer logic during the reception.
module mii_rx_err_classifier #(
    parameter int MAX_BYTES = 1518
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rxd,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic       crs,
    input  logic       fifo_ovr,
    output logic       ev_symbol,
    output logic       ev_fcs,
    output logic       ev_align,
    output logic       ev_long,
    output logic       ev_missed,
    output logic       ev_errored
);

    logic       rx_open, in_data, sfd_hit, byte_vld, nib_odd, frame_end;
    logic [7:0] byte_data;
    logic       crc_ok, too_long;
    logic       sym_q, ovr_q;
    logic       n_sym, n_fcs, n_align, n_long, n_missed;

    mii_rx_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .rx_dv     (rx_dv),
        .crs       (crs),
        .rx_open   (rx_open),
        .in_data   (in_data),
        .sfd_hit   (sfd_hit),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .nib_odd   (nib_odd),
        .frame_end (frame_end)
    );

    mii_rx_crc32 u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sfd_hit),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .crc_ok    (crc_ok)
    );

    mii_rx_len_cnt #(.MAX_BYTES(MAX_BYTES)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sfd_hit),
        .byte_vld (byte_vld),
        .too_long (too_long)
    );

    // Sticky symbol and overrun flags for the open reception.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            sym_q <= 1'b0;
            ovr_q <= 1'b0;
        end else begin
            sym_q <= sym_q | (rx_dv & rx_er);
            ovr_q <= ovr_q | (fifo_ovr & (rx_open | rx_dv));
        end
    end

    // Classification at reception close.
    always_comb begin
        n_sym    = frame_end & sym_q;
        n_fcs    = frame_end & in_data & !nib_odd & !crc_ok;
        n_align  = frame_end & in_data &  nib_odd & !crc_ok;
        n_long   = frame_end & in_data & too_long;
        n_missed = frame_end & (ovr_q | fifo_ovr);
    end

    // Registered event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_symbol  <= 1'b0;
            ev_fcs     <= 1'b0;
            ev_align   <= 1'b0;
            ev_long    <= 1'b0;
            ev_missed  <= 1'b0;
            ev_errored <= 1'b0;
        end else begin
            ev_symbol  <= n_sym;
            ev_fcs     <= n_fcs;
            ev_align   <= n_align;
            ev_long    <= n_long;
            ev_missed  <= n_missed;
            ev_errored <= n_sym | n_fcs | n_align | n_long | n_missed;
        end
    end

endmodule

// File: rtl/mii_rx_err_classifier_chk.sv
// Port-level checker for the MII receive error classifier.
module mii_rx_err_classifier_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_dv,
    input logic crs,
    input logic ev_symbol,
    input logic ev_fcs,
    input logic ev_align,
    input logic ev_long,
    input logic ev_missed,
    input logic ev_errored
);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(ev_symbol || ev_fcs || ev_align || ev_long || ev_missed || ev_errored));

    // R6
    cause_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_symbol || ev_fcs || ev_align || ev_long || ev_missed) |-> ev_errored);

    // R6
    err_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_errored |-> (ev_symbol || ev_fcs || ev_align || ev_long || ev_missed));

    // R3
    fcs_align_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_fcs && ev_align));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_errored |=> !ev_errored);

    // R7
    after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_errored |-> ($past(!rx_dv) && $past(!crs)));

endmodule

bind mii_rx_err_classifier mii_rx_err_classifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_dv      (rx_dv),
    .crs        (crs),
    .ev_symbol  (ev_symbol),
    .ev_fcs     (ev_fcs),
    .ev_align   (ev_align),
    .ev_long    (ev_long),
    .ev_missed  (ev_missed),
    .ev_errored (ev_errored)
);

// File: tb/mii_rx_err_classifier_tb.sv
`timescale 1ns/1ps
module mii_rx_err_classifier_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       rx_dv = 1'b0, rx_er = 1'b0, crs = 1'b0, fifo_ovr = 1'b0;
    logic       ev_symbol, ev_fcs, ev_align, ev_long, ev_missed, ev_errored;

    int checks = 0;
    int errors = 0;
    int unexp  = 0;
    int pops   = 0;

    logic [5:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] fbuf [0:1599];

    // Event vector order: {symbol, fcs, align, long, missed, errored}
    localparam logic [5:0] E_NONE  = 6'b000000;
    localparam logic [5:0] E_SYM   = 6'b100001;
    localparam logic [5:0] E_FCS   = 6'b010001;
    localparam logic [5:0] E_ALIGN = 6'b001001;
    localparam logic [5:0] E_LONG  = 6'b000101;
    localparam logic [5:0] E_MISS  = 6'b000011;

    always #2.5 clk = ~clk;

    mii_rx_err_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
        .crs(crs), .fifo_ovr(fifo_ovr), .ev_symbol(ev_symbol), .ev_fcs(ev_fcs),
        .ev_align(ev_align), .ev_long(ev_long), .ev_missed(ev_missed),
        .ev_errored(ev_errored)
    );

    // Monitor: pops expected vectors as event pulses appear.
    always @(negedge clk) begin
        logic [5:0] v, e;
        string t;
        v = {ev_symbol, ev_fcs, ev_align, ev_long, ev_missed, ev_errored};
        if (rst_n && v != 6'b0) begin
            if (exp_q.size() == 0) begin
                unexp++; errors++;
                $display("FAIL R7 unexpected event actual %b expected none", v);
            end else begin
                e = exp_q.pop_front(); t = tag_q.pop_front();
                pops++; checks++;
                if (v !== e) begin
                    errors++;
                    $display("FAIL %s event vector actual %b expected %b", t, v, e);
                end
            end
        end
    end

    function automatic logic [31:0] ref_fcs(input int n);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, fbuf[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic nib(input logic [3:0] n, input logic er, input logic ov);
        @(negedge clk);
        rxd = n; rx_dv = 1'b1; crs = 1'b1; rx_er = er; fifo_ovr = ov;
    endtask

    task automatic close_rx(input int tail, input string tag);
        int p0;
        @(negedge clk);
        rx_dv = 1'b0; rx_er = 1'b0; fifo_ovr = 1'b0; crs = (tail > 0);
        if (tail > 0) begin
            p0 = pops;
            repeat (tail) @(negedge clk);
            checks++;
            if (pops != p0 || unexp != 0) begin
                errors++;
                $display("FAIL %s event during carrier tail actual %0d expected 0", tag, pops - p0);
            end
            crs = 1'b0;
        end
        repeat (4) @(negedge clk);
    endtask

    // Driver: build frame, queue expectation, drive nibbles, then verify queue drained.
    task automatic send(input int npay, input logic corrupt, input logic dribble,
                        input int er_lo, input int er_hi, input int ovr_at,
                        input int tail, input logic [5:0] exp, input string tag);
        logic [31:0] f;
        int k, u0;
        for (int i = 0; i < npay; i++) fbuf[i] = 8'(i * 7 + npay);
        f = ref_fcs(npay);
        for (int i = 0; i < 4; i++) fbuf[npay + i] = f[8*i +: 8];
        if (corrupt) fbuf[2] = fbuf[2] ^ 8'h10;
        if (exp != E_NONE) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        u0 = unexp;
        for (int i = 0; i < 15; i++) nib(4'h5, 1'b0, 1'b0);
        nib(4'hD, 1'b0, 1'b0);
        k = 0;
        for (int i = 0; i < npay + 4; i++) begin
            nib(fbuf[i][3:0], (k >= er_lo && k <= er_hi), (k == ovr_at)); k++;
            nib(fbuf[i][7:4], (k >= er_lo && k <= er_hi), (k == ovr_at)); k++;
        end
        if (dribble) nib(4'hA, 1'b0, 1'b0);
        close_rx(tail, tag);
        checks++;
        if (exp_q.size() != 0 || unexp != u0) begin
            errors++;
            $display("FAIL %s pending or extra events actual %0d/%0d expected 0/0",
                     tag, exp_q.size(), unexp - u0);
            exp_q.delete(); tag_q.delete();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({ev_symbol, ev_fcs, ev_align, ev_long, ev_missed, ev_errored} !== 6'b0) begin
            errors++;
            $display("FAIL R9 outputs in reset actual %b expected 000000",
                     {ev_symbol, ev_fcs, ev_align, ev_long, ev_missed, ev_errored});
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send(60, 0, 0, -1, -1, -1, 0, E_NONE,  "R10");       // clean frame
        send(60, 1, 0, -1, -1, -1, 0, E_FCS,   "R2");        // bad CRC, even
        send(46, 0, 1, -1, -1, -1, 0, E_NONE,  "R3");        // dribble, good CRC
        send(46, 1, 1, -1, -1, -1, 0, E_ALIGN, "R3");        // dribble, bad CRC
        send(64, 0, 0, 10, 14, -1, 0, E_SYM,   "R1");        // rx_er over 5 nibbles
        send(64, 1, 0, 3, 3, -1, 0, E_SYM | E_FCS, "R6");    // combined causes
        send(1514, 0, 0, -1, -1, -1, 0, E_NONE, "R4");       // exactly 1518 bytes
        send(1515, 0, 0, -1, -1, -1, 0, E_LONG, "R4");       // 1519 bytes
        send(80, 0, 0, -1, -1, 40, 0, E_MISS,  "R5");        // overrun mid frame
        send(60, 1, 0, -1, -1, -1, 6, E_FCS,   "R7");        // carrier tail

        // R5: overrun while idle is ignored
        repeat (3) begin @(negedge clk); fifo_ovr = 1'b1; end
        @(negedge clk); fifo_ovr = 1'b0;
        repeat (4) @(negedge clk);
        checks++;
        if (unexp != 0) begin
            errors++;
            $display("FAIL R5 idle overrun produced events actual %0d expected 0", unexp);
        end

        // R8: reception without delimiter, with one rx_er
        exp_q.push_back(E_SYM); tag_q.push_back("R8");
        for (int i = 0; i < 12; i++) nib(4'h5, (i == 4), 1'b0);
        close_rx(0, "R8");
        // R8: delimiter nibble without preceding 0x5 and bad data: no CRC events
        for (int i = 0; i < 6; i++) nib(4'h3, 1'b0, 1'b0);
        nib(4'hD, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) nib(4'h1, 1'b0, 1'b0);
        close_rx(0, "R8");
        checks++;
        if (exp_q.size() != 0 || unexp != 0) begin
            errors++;
            $display("FAIL R8 undelimited reception actual %0d/%0d expected 0/0",
                     exp_q.size(), unexp);
        end

        send(60, 0, 0, -1, -1, -1, 0, E_NONE, "R10");        // flags cleared

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule